// File: doc/BRIEF.md
# Test Access Port Controller with Auxiliary Port Handoff

This block is a serial test access port for a chip's scan and debug logic. It runs the standard 16-state TAP state machine from TCK and TMS. A 5-bit instruction register decides which data register sits between TDI and TDO:
- a 32-bit device identification register;
- a 1-bit bypass register;
- an external boundary-scan chain, reached through a select line, capture, shift and update strobes, and a serial return input.

The instruction also drives three chip-wide control lines: output three-state, apply-preloaded-values and functional reset.

A whole-port enable input gates the TAP. While the enable is low, the controller sits in its reset state and TDO is not driven. A group of instruction codes gives the serial port to one of four auxiliary TAP controllers. Once the port is given away, TMS and TDI are steered to that controller and its TDO is returned. This lasts until the enable drops or the test reset is asserted. The auxiliary controllers are seen here only as stub ports.

Top module: `jtag_tap_aux`

## Requirements
- R1: While `tap_en` is 0, the controller is held in Test-Logic-Reset. `tdo_oe` is 0, `aux_own` is 0, `pin_hiz`, `pin_apply`, `func_rst` and `bsr_sel` are 0, and the active instruction returns to IDCODE (00001).
- R2: `trst_n` low resets the controller asynchronously in the same way. After any reset the active instruction is IDCODE.
- R3: State changes on the rising TCK edge follow the standard 16-state TAP graph. Five rising edges with TMS=1 reach Test-Logic-Reset from any state, and that state reloads IDCODE as the active instruction.
- R4: Capture-IR loads 00001 into the instruction shifter. Shift-IR moves it toward TDO least-significant bit first, so bit 0 (value 1) appears first. A new instruction takes effect only on the rising edge that leaves Update-IR.
- R5: With IDCODE active, Capture-DR loads `ID_VALUE` with bit 0 forced to 1. Shift-DR returns it least-significant bit first. TDO changes only on the falling TCK edge, and `tdo_oe` is 1 exactly while the state is Shift-DR or Shift-IR.
- R6: Leaving Shift-DR after any number of bits corrupts nothing. The next Capture-DR reloads the complete register value.
- R7: Instruction decoding for the boundary-scan chain:
  - SAMPLE (00011) and SAMPLE/PRELOAD (00010) set `bsr_sel` and leave all three control lines at 0.
  - EXTEST (00100) sets `bsr_sel`, `pin_apply` and `func_rst`.
- R8: Instruction decoding for the bypass-based controls:
  - HIGHZ (01001) selects bypass and sets `pin_hiz` and `func_rst`.
  - CLAMP (01100) selects bypass and sets `pin_apply` and `func_rst`.
- R9: Every other code that does not grant the port selects the 1-bit bypass register. This includes 00000, 00111, 10100 to 11111 and the rest of the unlisted codes. The bypass register captures 0, so TDO returns TDI delayed by one shift.
- R10: While `bsr_sel` is 1, each of `bsr_capture`, `bsr_shift` and `bsr_update` is high exactly in Capture-DR, Shift-DR and Update-DR respectively. During Shift-DR, TDO returns `bsr_so`.
- R11: Codes 100nn, with nn from 0 to 3, grant the port to auxiliary controller nn on leaving Update-IR. After the grant:
  - `aux_own` is one-hot at bit nn.
  - `aux_tms[nn]` follows TMS and `aux_tdi[nn]` follows TDI.
  - The other controllers see TMS=1 and TDI=0.
  - TDO equals `aux_tdo[nn]` and `tdo_oe` is 1.
- R12: A grant holds whatever TMS and TDI do. Only `tap_en` low or `trst_n` low releases it, after which the controller restarts in Test-Logic-Reset with IDCODE active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_en | input | 1 | Whole-port enable, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | TDO drive enable (0 = three-stated) |
| bsr_so | input | 1 | Serial return from the external boundary-scan chain |
| bsr_sel | output | 1 | Boundary-scan chain selected by the active instruction |
| bsr_capture | output | 1 | Boundary-scan capture strobe |
| bsr_shift | output | 1 | Boundary-scan shift strobe |
| bsr_update | output | 1 | Boundary-scan update strobe |
| pin_hiz | output | 1 | Three-state all functional outputs |
| pin_apply | output | 1 | Drive preloaded boundary values onto the outputs |
| func_rst | output | 1 | Hold functional logic in reset |
| aux_tdo | input | NAUX | Serial data returned by each auxiliary controller |
| aux_own | output | NAUX | One-hot port ownership grant |
| aux_tms | output | NAUX | TMS steered to each auxiliary controller |
| aux_tdi | output | NAUX | TDI steered to each auxiliary controller |

## Verification
State-derived outputs change in the same rising edge that enters a state:
- the control lines, the boundary-scan strobes and `aux_own`;
- `aux_tms` and `aux_tdi`, which follow TMS and TDI with no register.

The serial TDO and `tdo_oe` are registered on the following falling edge, and a new instruction or grant takes effect at the rising edge that leaves Update-IR. The bench drives TMS and TDI just after a falling edge and advances its reference model at the rising edge. It samples every output 1 ns after the next falling edge, where all of these results have settled. Shifted-out words are rebuilt from those samples and compared as a whole.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_EXIT2_DR = 4'h0,
    ST_EXIT1_DR = 4'h1,
    ST_SHIFT_DR = 4'h2,
    ST_PAUSE_DR = 4'h3,
    ST_SEL_IR   = 4'h4,
    ST_UPD_DR   = 4'h5,
    ST_CAP_DR   = 4'h6,
    ST_SEL_DR   = 4'h7,
    ST_EXIT2_IR = 4'h8,
    ST_EXIT1_IR = 4'h9,
    ST_SHIFT_IR = 4'hA,
    ST_PAUSE_IR = 4'hB,
    ST_IDLE     = 4'hC,
    ST_UPD_IR   = 4'hD,
    ST_CAP_IR   = 4'hE,
    ST_RESET    = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OPC_IDCODE     = 5'b00001;
  localparam logic [IR_W-1:0] OPC_SAMPLE_PRE = 5'b00010;
  localparam logic [IR_W-1:0] OPC_SAMPLE     = 5'b00011;
  localparam logic [IR_W-1:0] OPC_EXTEST     = 5'b00100;
  localparam logic [IR_W-1:0] OPC_HIGHZ      = 5'b01001;
  localparam logic [IR_W-1:0] OPC_CLAMP      = 5'b01100;
  localparam logic [IR_W-1:0] IR_CAPT_VAL    = 5'b00001;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BSR} dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    hiz;
    logic    apply;
    logic    frst;
  } ir_ctrl_t;

  // Standard TAP graph, one rising TCK edge.
  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    tap_state_e n;
    case (s)
      ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   n = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: n = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: n = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: n = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   n = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   n = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: n = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: n = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: n = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   n = tms ? ST_SEL_DR   : ST_IDLE;
      default:     n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic ir_ctrl_t ir_decode(logic [IR_W-1:0] op);
    ir_ctrl_t c;
    c.dr    = DR_BYPASS;
    c.hiz   = 1'b0;
    c.apply = 1'b0;
    c.frst  = 1'b0;
    case (op)
      OPC_IDCODE:                 c.dr = DR_IDCODE;
      OPC_SAMPLE, OPC_SAMPLE_PRE: c.dr = DR_BSR;
      OPC_EXTEST: begin
        c.dr    = DR_BSR;
        c.apply = 1'b1;
        c.frst  = 1'b1;
      end
      OPC_HIGHZ: begin
        c.hiz  = 1'b1;
        c.frst = 1'b1;
      end
      OPC_CLAMP: begin
        c.apply = 1'b1;
        c.frst  = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Codes 100nn hand the port to auxiliary controller nn, when it exists.
  function automatic logic is_aux_code(logic [IR_W-1:0] op, int naux);
    return (op[4:2] == 3'b100) && (int'(op[1:0]) < naux);
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  input  logic       hold,
  output tap_state_e state,
  output logic       in_tlr,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       upd_dr,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       upd_ir
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)    state <= ST_RESET;
    else if (hold) state <= ST_IDLE;
    else           state <= tap_next(state, tms);
  end

  assign in_tlr = (state == ST_RESET);
  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SHIFT_DR);
  assign upd_dr = (state == ST_UPD_DR);
  assign cap_ir = (state == ST_CAP_IR);
  assign sh_ir  = (state == ST_SHIFT_IR);
  assign upd_ir = (state == ST_UPD_IR);

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int NAUX = 4,
  localparam int AIW = (NAUX > 1) ? $clog2(NAUX) : 1
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_active,
  output logic            gnt,
  output logic [AIW-1:0]  gnt_idx
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr     <= IR_CAPT_VAL;
      ir_active <= OPC_IDCODE;
      gnt       <= 1'b0;
      gnt_idx   <= '0;
    end else begin
      if (cap_ir)     ir_sr <= IR_CAPT_VAL;
      else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

      if (in_tlr)      ir_active <= OPC_IDCODE;
      else if (upd_ir) ir_active <= ir_sr;

      if (upd_ir && is_aux_code(ir_sr, NAUX)) begin
        gnt     <= 1'b1;
        gnt_idx <= ir_sr[AIW-1:0];
      end
    end
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr #(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5E_C0DE
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic cap_dr,
  input  logic sh_dr,
  output logic id_lsb,
  output logic byp_q
);

  localparam logic [ID_W-1:0] ID_CAPT = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sr;

  // Read-only registers: nothing is written back, so an early exit is harmless.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else if (cap_dr) begin
      id_sr <= ID_CAPT;
      byp_q <= 1'b0;
    end else if (sh_dr) begin
      id_sr <= {tdi, id_sr[ID_W-1:1]};
      byp_q <= tdi;
    end
  end

  assign id_lsb = id_sr[0];

endmodule

// File: rtl/jtag_tap_aux.sv
module jtag_tap_aux
  import jtag_tap_pkg::*;
#(
  parameter int              NAUX     = 4,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5E_C0DE
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tap_en,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic            bsr_so,
  output logic            bsr_sel,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            pin_hiz,
  output logic            pin_apply,
  output logic            func_rst,
  input  logic [NAUX-1:0] aux_tdo,
  output logic [NAUX-1:0] aux_own,
  output logic [NAUX-1:0] aux_tms,
  output logic [NAUX-1:0] aux_tdi
);

  localparam int AIW = (NAUX > 1) ? $clog2(NAUX) : 1;

  logic            tap_rst_n;
  tap_state_e      tap_state;
  logic            in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir_evt;
  logic [IR_W-1:0] ir_active;
  logic            ir_lsb, gnt, id_lsb, byp_q;
  logic [AIW-1:0]  gnt_idx;
  ir_ctrl_t        ctrl;
  logic            tdo_d, tdo_q, oe_q;

  // The enable and the test reset both force the port back to reset.
  assign tap_rst_n = trst_n & tap_en;

  jtag_tap_fsm u_fsm (
    .tck    (tck),
    .rst_n  (tap_rst_n),
    .tms    (tms),
    .hold   (gnt),
    .state  (tap_state),
    .in_tlr (in_tlr),
    .cap_dr (cap_dr),
    .sh_dr  (sh_dr),
    .upd_dr (upd_dr),
    .cap_ir (cap_ir),
    .sh_ir  (sh_ir),
    .upd_ir (upd_ir_evt)
  );

  jtag_tap_ir #(.NAUX(NAUX)) u_ir (
    .tck       (tck),
    .rst_n     (tap_rst_n),
    .tdi       (tdi),
    .in_tlr    (in_tlr),
    .cap_ir    (cap_ir),
    .sh_ir     (sh_ir),
    .upd_ir    (upd_ir_evt),
    .ir_lsb    (ir_lsb),
    .ir_active (ir_active),
    .gnt       (gnt),
    .gnt_idx   (gnt_idx)
  );

  jtag_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (tap_rst_n),
    .tdi    (tdi),
    .cap_dr (cap_dr),
    .sh_dr  (sh_dr),
    .id_lsb (id_lsb),
    .byp_q  (byp_q)
  );

  assign ctrl        = ir_decode(ir_active);
  assign bsr_sel     = (ctrl.dr == DR_BSR);
  assign bsr_capture = bsr_sel & cap_dr;
  assign bsr_shift   = bsr_sel & sh_dr;
  assign bsr_update  = bsr_sel & upd_dr;
  assign pin_hiz     = ctrl.hiz;
  assign pin_apply   = ctrl.apply;
  assign func_rst    = ctrl.frst;

  always_comb begin
    tdo_d = 1'b0;
    if (sh_ir) begin
      tdo_d = ir_lsb;
    end else if (sh_dr) begin
      case (ctrl.dr)
        DR_IDCODE: tdo_d = id_lsb;
        DR_BSR:    tdo_d = bsr_so;
        default:   tdo_d = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= sh_ir | sh_dr;
    end
  end

  assign tdo    = gnt ? aux_tdo[gnt_idx] : tdo_q;
  assign tdo_oe = gnt | oe_q;

  for (genvar i = 0; i < NAUX; i++) begin : g_aux
    assign aux_own[i] = gnt && (gnt_idx == AIW'(i));
    assign aux_tms[i] = aux_own[i] ? tms : 1'b1;
    assign aux_tdi[i] = aux_own[i] & tdi;
  end

endmodule

// File: rtl/jtag_tap_aux_chk.sv
module jtag_tap_aux_chk
  import jtag_tap_pkg::*;
#(
  parameter int NAUX = 4
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tap_en,
  input logic            tdo_oe,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pin_hiz,
  input logic            func_rst,
  input logic [NAUX-1:0] aux_own,
  input tap_state_e      tap_state,
  input logic [IR_W-1:0] ir_active,
  input logic            upd_ir_evt
);

  logic rst_act;
  assign rst_act = !(trst_n && tap_en);

  a_r1_disabled_quiet: assert property (@(posedge tck)
    !tap_en |-> (!tdo_oe && (aux_own == '0)));

  a_r4_ir_waits_update: assert property (@(posedge tck) disable iff (rst_act)
    (!upd_ir_evt && tap_state != ST_RESET) |=> $stable(ir_active));

  a_r5_oe_only_shift: assert property (@(posedge tck) disable iff (rst_act)
    (tdo_oe && aux_own == '0) |-> (tap_state == ST_SHIFT_DR || tap_state == ST_SHIFT_IR));

  a_r8_hiz_with_reset: assert property (@(posedge tck) disable iff (rst_act)
    pin_hiz |-> func_rst);

  a_r10_strobes_exclusive: assert property (@(posedge tck) disable iff (rst_act)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  a_r11_own_onehot: assert property (@(posedge tck) disable iff (rst_act)
    $onehot0(aux_own));

  a_r12_own_sticky: assert property (@(posedge tck) disable iff (rst_act)
    (aux_own != '0) |=> (aux_own == $past(aux_own)));

endmodule

bind jtag_tap_aux jtag_tap_aux_chk #(.NAUX(NAUX)) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .tap_en      (tap_en),
  .tdo_oe      (tdo_oe),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update),
  .pin_hiz     (pin_hiz),
  .func_rst    (func_rst),
  .aux_own     (aux_own),
  .tap_state   (tap_state),
  .ir_active   (ir_active),
  .upd_ir_evt  (upd_ir_evt)
);

// File: tb/test_jtag_tap_aux.sv
module test_jtag_tap_aux;

  localparam int NA = 4;
  localparam logic [31:0] ID_EXP = 32'h1A5E_C0DF;

  localparam int T_RESET = 0, T_IDLE = 1, T_SDR = 2, T_CDR = 3, T_SHDR = 4, T_E1DR = 5,
                 T_PDR = 6, T_E2DR = 7, T_UDR = 8, T_SIR = 9, T_CIR = 10, T_SHIR = 11,
                 T_E1IR = 12, T_PIR = 13, T_E2IR = 14, T_UIR = 15;

  logic tck = 1'b0;
  logic trst_n, tap_en, tms, tdi, bsr_so;
  logic [NA-1:0] aux_tdo;
  logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update, pin_hiz, pin_apply, func_rst;
  logic [NA-1:0] aux_own, aux_tms, aux_tdi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_st;
  logic [4:0] m_ir, m_irsr;
  logic [31:0] m_id;
  logic m_byp, m_gnt;
  int m_idx;
  logic last_tdo;

  always #5 tck = ~tck;

  jtag_tap_aux i_jtag_tap_aux (
    .tck(tck), .trst_n(trst_n), .tap_en(tap_en), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_so(bsr_so), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .pin_hiz(pin_hiz), .pin_apply(pin_apply), .func_rst(func_rst),
    .aux_tdo(aux_tdo), .aux_own(aux_own), .aux_tms(aux_tms), .aux_tdi(aux_tdi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(int s, logic t);
    case (s)
      T_RESET: return t ? T_RESET : T_IDLE;
      T_IDLE:  return t ? T_SDR : T_IDLE;
      T_SDR:   return t ? T_SIR : T_CDR;
      T_CDR, T_SHDR: return t ? T_E1DR : T_SHDR;
      T_E1DR:  return t ? T_UDR : T_PDR;
      T_PDR:   return t ? T_E2DR : T_PDR;
      T_E2DR:  return t ? T_UDR : T_SHDR;
      T_SIR:   return t ? T_RESET : T_CIR;
      T_CIR, T_SHIR: return t ? T_E1IR : T_SHIR;
      T_E1IR:  return t ? T_UIR : T_PIR;
      T_PIR:   return t ? T_E2IR : T_PIR;
      T_E2IR:  return t ? T_UIR : T_SHIR;
      default: return t ? T_SDR : T_IDLE;  // both update states
    endcase
  endfunction

  // bench-side decoding: 0 bypass, 1 id, 2 boundary
  function automatic int sel_of(logic [4:0] op);
    if (op == 5'd1) return 1;
    if (op == 5'd2 || op == 5'd3 || op == 5'd4) return 2;
    return 0;
  endfunction

  task automatic model_edge(input logic t, input logic d);
    if (!(trst_n && tap_en)) begin
      m_st = T_RESET; m_ir = 5'd1; m_gnt = 1'b0; m_idx = 0;
    end else if (m_gnt) begin
      m_st = T_IDLE;
    end else begin
      case (m_st)
        T_RESET: m_ir = 5'd1;
        T_CIR:   m_irsr = 5'b00001;
        T_SHIR:  m_irsr = {d, m_irsr[4:1]};
        T_CDR:   begin m_id = ID_EXP; m_byp = 1'b0; end
        T_SHDR:  begin m_id = {d, m_id[31:1]}; m_byp = d; end
        T_UIR: begin
          m_ir = m_irsr;
          if (m_irsr[4:2] == 3'b100) begin m_gnt = 1'b1; m_idx = int'(m_irsr[1:0]); end
        end
        default: ;
      endcase
      m_st = nxt(m_st, t);
    end
  endtask

  task automatic compare();
    logic exp_oe, exp_tdo;
    logic [NA-1:0] e_own, e_tms, e_tdi;
    string ttag;
    int s;
    s = sel_of(m_ir);
    exp_oe = m_gnt || m_st == T_SHDR || m_st == T_SHIR;
    if (m_gnt) begin ttag = "R11 tdo from owner"; exp_tdo = aux_tdo[m_idx]; end
    else if (m_st == T_SHIR) begin ttag = "R4 tdo in Shift-IR"; exp_tdo = m_irsr[0]; end
    else if (s == 1) begin ttag = "R5 tdo idcode"; exp_tdo = m_id[0]; end
    else if (s == 2) begin ttag = "R10 tdo boundary"; exp_tdo = bsr_so; end
    else begin ttag = "R9 tdo bypass"; exp_tdo = m_byp; end
    chk(m_gnt ? "R11 tdo_oe" : "R5 tdo_oe", tdo_oe, exp_oe);
    if (exp_oe) chk(ttag, tdo, exp_tdo);
    chk("R7 bsr_sel", bsr_sel, s == 2);
    chk("R8 pin_hiz", pin_hiz, m_ir == 5'b01001);
    chk("R7 pin_apply", pin_apply, m_ir == 5'b00100 || m_ir == 5'b01100);
    chk("R8 func_rst", func_rst, m_ir == 5'b00100 || m_ir == 5'b01001 || m_ir == 5'b01100);
    chk("R10 bsr_capture", bsr_capture, s == 2 && m_st == T_CDR);
    chk("R10 bsr_shift", bsr_shift, s == 2 && m_st == T_SHDR);
    chk("R10 bsr_update", bsr_update, s == 2 && m_st == T_UDR);
    for (int i = 0; i < NA; i++) begin
      e_own[i] = m_gnt && m_idx == i;
      e_tms[i] = e_own[i] ? tms : 1'b1;
      e_tdi[i] = e_own[i] ? tdi : 1'b0;
    end
    chk("R11 aux_own", aux_own, e_own);
    chk("R11 aux_tms", aux_tms, e_tms);
    chk("R11 aux_tdi", aux_tdi, e_tdi);
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck);
    model_edge(t, d);
    @(negedge tck);
    #1;
    compare();
    last_tdo = tdo;
  endtask

  // From Run-Test/Idle: load an instruction, return the captured IR bits.
  task automatic load_ir(input logic [4:0] code, output logic [4:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = last_tdo;
    for (int k = 0; k < 5; k++) begin
      step(k == 4, code[k]);
      if (k < 4) cap[k+1] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  // From Run-Test/Idle: shift n data bits, return what came out.
  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = last_tdo;
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k]);
      if (k < n - 1) dout[k+1] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] cap;
    logic [63:0] d;
    trst_n = 0; tap_en = 1; tms = 1; tdi = 0; bsr_so = 0; aux_tdo = 4'b1010;
    m_st = T_RESET; m_ir = 5'd1; m_irsr = 5'd1; m_id = '0; m_byp = 0; m_gnt = 0; m_idx = 0;
    last_tdo = 0;
    @(negedge tck); #1;
    step(1, 0); step(1, 0);
    chk("R2 reset tdo_oe", tdo_oe, 0);
    chk("R2 reset func_rst", func_rst, 0);
    chk("R2 reset bsr_sel", bsr_sel, 0);
    chk("R2 reset aux_own", aux_own, 0);
    trst_n = 1;
    step(0, 0);

    shift_dr(32, 64'h0, d);
    chk("R5 idcode word", d[31:0], ID_EXP);
    shift_dr(7, 64'h7F, d);
    chk("R6 partial read", d[6:0], ID_EXP[6:0]);
    shift_dr(32, 64'h0, d);
    chk("R6 full reload after early exit", d[31:0], ID_EXP);

    load_ir(5'b00111, cap);
    chk("R4 capture-IR pattern", cap, 5'b00001);
    shift_dr(4, 64'b1011, d);
    chk("R9 bypass delay", d[3:0], 4'b0110);

    repeat (5) step(1, 0);
    step(0, 0);
    shift_dr(32, 64'h0, d);
    chk("R3 TLR restores idcode", d[31:0], ID_EXP);

    load_ir(5'b00011, cap);
    chk("R7 sample selects chain", bsr_sel, 1);
    chk("R7 sample no reset", func_rst, 0);
    bsr_so = 1;
    shift_dr(3, 64'h0, d);
    chk("R10 chain return", d[2:0], 3'b111);
    bsr_so = 0;
    load_ir(5'b00010, cap);
    shift_dr(2, 64'h3, d);
    load_ir(5'b00100, cap);
    chk("R7 extest apply", pin_apply, 1);
    chk("R7 extest reset", func_rst, 1);
    load_ir(5'b01001, cap);
    chk("R8 highz", pin_hiz, 1);
    shift_dr(3, 64'b101, d);
    chk("R8 highz uses bypass", d[2:0], 3'b010);
    load_ir(5'b01100, cap);
    chk("R8 clamp apply", pin_apply, 1);
    chk("R8 clamp not hiz", pin_hiz, 0);

    // enable drop in the middle of a shift
    load_ir(5'b00100, cap);
    step(1, 0); step(0, 0); step(0, 1);
    tap_en = 0;
    step(0, 1);
    chk("R1 disabled tdo_oe", tdo_oe, 0);
    chk("R1 disabled func_rst", func_rst, 0);
    step(0, 0);
    tap_en = 1;
    step(0, 0);
    shift_dr(32, 64'h0, d);
    chk("R1 idcode after enable", d[31:0], ID_EXP);

    // grant to auxiliary 2
    load_ir(5'b10010, cap);
    chk("R11 grant aux2", aux_own, 4'b0100);
    for (int k = 0; k < 12; k++) begin
      if (k == 6) aux_tdo = 4'b0101;
      step(k[0] ^ k[2], k[1]);
    end
    chk("R12 grant persists", aux_own, 4'b0100);
    tap_en = 0;
    step(1, 0);
    chk("R12 enable drop releases", aux_own, 0);
    tap_en = 1;
    step(0, 0);

    load_ir(5'b10100, cap);
    chk("R9 code 10100 no grant", aux_own, 0);
    shift_dr(3, 64'b011, d);
    chk("R9 code 10100 bypass", d[2:0], 3'b110);

    load_ir(5'b10011, cap);
    chk("R11 grant aux3", aux_own, 4'b1000);
    repeat (6) step(1, 1);
    trst_n = 0;
    step(1, 0);
    chk("R12 trst releases", aux_own, 0);
    trst_n = 1;
    step(0, 0);
    shift_dr(32, 64'h0, d);
    chk("R12 idcode after release", d[31:0], ID_EXP);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule